// File: doc/BRIEF.md
# Interleaved DRAM Node Address Router

This block decides which of eight memory nodes owns a 40-bit physical address. Software loads eight address windows through a register write port. Each window has a base word and a limit word. The base word carries the read and write enables, an interleave code and the lower bound on address bits 39..24. The limit word carries the upper bound, a 3-bit interleave select value and the 3-bit destination node.

For each request, the block checks the address against all eight windows in parallel. It registers a result that has four parts: a hit flag, the winning window index, the destination node and an access-denied flag. The result is valid one cycle after the request.

Node interleaving narrows a window. Selected address bits among A12, A13 and A14 must also equal the window's select value. This lets several windows that share one address range split it across nodes on fine-grained boundaries.

Top module: `dram_node_router`

## Requirements
- R1: Eight windows are written through `cfg_we`, `cfg_idx` and `cfg_sel_limit`. `cfg_sel_limit`=1 selects the limit word, which has the node in [2:0], the select value in [10:8] and the limit in [31:16]. `cfg_sel_limit`=0 selects the base word, which has read enable in [0], write enable in [1], the interleave code in [10:8] and the base in [31:16].
- R2: A window's range matches when base <= A[39:24] <= limit. Both bounds are inclusive.
- R3: A request hits a window only if that window enables the request's type (`req_write`=0 is a read). When no window hits, `rsp_denied` is 1 if some window with at least one enable set matches on range and interleave but does not enable this type.
- R4: Interleave codes select which address bits are compared with the select value. Code 000 compares none. Code 001 compares A12. Code 011 compares A12 and A14. Code 111 compares A12, A13 and A14. The select value's bit 0, bit 1 and bit 2 are compared with A12, A13 and A14 respectively.
- R5: A base write with any other interleave code makes that window behave as having no interleave. It also sets `cfg_err`, which stays 1 until reset.
- R6: When several windows hit, the lowest-numbered one wins. Its index goes to `rsp_region` and its node goes to `rsp_node`.
- R7: `rsp_valid` is 1 exactly in the cycle after `req_valid` is 1. A configuration write applies to requests presented in the following cycle or later, so a window becomes live as soon as its base is written with an enable set.
- R8: On a miss, `rsp_hit`=0, `rsp_node`=0 and `rsp_region`=0.
- R9: After reset, every window is disabled, `rsp_valid`=0 and `cfg_err`=0.
- R10: `rsp_hit` and `rsp_denied` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel_limit | input | 1 | 1 = limit word, 0 = base word |
| cfg_idx | input | 3 | Window index |
| cfg_wdata | input | 32 | Configuration word |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_addr | input | 40 | Physical address |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | A window accepted the request |
| rsp_node | output | 3 | Destination node |
| rsp_region | output | 3 | Winning window index |
| rsp_denied | output | 1 | Matched only windows that forbid this access type |
| cfg_err | output | 1 | Sticky reserved-interleave-code flag |

## Verification
Stored window state is reached only through routing results. A corrupted bound, enable, mask or node therefore shows up on the very next request that lands in the affected range: the result is wrong one cycle after `req_valid`. Overlapping windows and shared-range interleave pairs are stimulated together, so a broken priority chain or an inverted mask bit changes `rsp_region` rather than hiding behind a single matching window. The sticky error flag is checked both when it sets and after a later legal write, so a flag that clears on rewrite is exposed at once.

// File: rtl/drr_pkg.sv
package drr_pkg;
  localparam int ILV_W = 3;

  typedef enum logic [ILV_W-1:0] {
    ILV_OFF   = 3'b000,
    ILV_TWO   = 3'b001,
    ILV_FOUR  = 3'b011,
    ILV_EIGHT = 3'b111
  } ilv_code_e;

  // Decoded compare mask: bit0 -> A12, bit1 -> A13, bit2 -> A14.
  function automatic logic [ILV_W-1:0] ilv_mask(input logic [ILV_W-1:0] code);
    case (code)
      ILV_TWO:   ilv_mask = 3'b001;
      ILV_FOUR:  ilv_mask = 3'b101;
      ILV_EIGHT: ilv_mask = 3'b111;
      default:   ilv_mask = 3'b000;
    endcase
  endfunction

  function automatic logic ilv_reserved(input logic [ILV_W-1:0] code);
    ilv_reserved = !(code == ILV_OFF || code == ILV_TWO ||
                     code == ILV_FOUR || code == ILV_EIGHT);
  endfunction
endpackage

// File: rtl/drr_regfile.sv
module drr_regfile
  import drr_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int FLD_W   = 16,
  parameter int NODE_W  = 3,
  parameter int CFG_W   = 32,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic                            cfg_sel_limit,
  input  logic [IDX_W-1:0]                cfg_idx,
  input  logic [CFG_W-1:0]                cfg_wdata,
  output logic [NUM_WIN-1:0]              win_rd,
  output logic [NUM_WIN-1:0]              win_wr,
  output logic [NUM_WIN-1:0][ILV_W-1:0]   win_mask,
  output logic [NUM_WIN-1:0][ILV_W-1:0]   win_sel,
  output logic [NUM_WIN-1:0][NODE_W-1:0]  win_node,
  output logic [NUM_WIN-1:0][FLD_W-1:0]   win_lo,
  output logic [NUM_WIN-1:0][FLD_W-1:0]   win_hi,
  output logic                            err_flag
);
  localparam int ILV_LSB = 8;
  localparam int FLD_MSB = CFG_W - 1;

  logic [ILV_W-1:0] wr_code;
  logic             base_wr_any;
  logic             err_d;

  assign wr_code     = cfg_wdata[ILV_LSB +: ILV_W];
  assign base_wr_any = cfg_we && !cfg_sel_limit;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic             base_en, lim_en;
    logic             rd_d, wr_d;
    logic [ILV_W-1:0] mask_d, sel_d;
    logic [NODE_W-1:0] node_d;
    logic [FLD_W-1:0] lo_d, hi_d;

    assign base_en = base_wr_any && (cfg_idx == IDX_W'(g));
    assign lim_en  = cfg_we && cfg_sel_limit && (cfg_idx == IDX_W'(g));

    always_comb begin
      rd_d   = win_rd[g];
      wr_d   = win_wr[g];
      mask_d = win_mask[g];
      lo_d   = win_lo[g];
      sel_d  = win_sel[g];
      node_d = win_node[g];
      hi_d   = win_hi[g];
      if (base_en) begin
        rd_d   = cfg_wdata[0];
        wr_d   = cfg_wdata[1];
        mask_d = ilv_mask(wr_code);
        lo_d   = cfg_wdata[FLD_MSB -: FLD_W];
      end
      if (lim_en) begin
        node_d = cfg_wdata[NODE_W-1:0];
        sel_d  = cfg_wdata[ILV_LSB +: ILV_W];
        hi_d   = cfg_wdata[FLD_MSB -: FLD_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_rd[g]   <= 1'b0;
        win_wr[g]   <= 1'b0;
        win_mask[g] <= '0;
        win_lo[g]   <= '0;
      end else if (base_en) begin
        win_rd[g]   <= rd_d;
        win_wr[g]   <= wr_d;
        win_mask[g] <= mask_d;
        win_lo[g]   <= lo_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_node[g] <= '0;
        win_sel[g]  <= '0;
        win_hi[g]   <= '0;
      end else if (lim_en) begin
        win_node[g] <= node_d;
        win_sel[g]  <= sel_d;
        win_hi[g]   <= hi_d;
      end
    end
  end

  assign err_d = err_flag || (base_wr_any && ilv_reserved(wr_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_flag <= 1'b0;
    else        err_flag <= err_d;
  end
endmodule

// File: rtl/drr_window_match.sv
module drr_window_match
  import drr_pkg::*;
#(
  parameter int FLD_W = 16
) (
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [ILV_W-1:0] mask,
  input  logic [ILV_W-1:0] sel,
  input  logic [FLD_W-1:0] lo,
  input  logic [FLD_W-1:0] hi,
  input  logic             is_write,
  input  logic [FLD_W-1:0] addr_fld,
  input  logic [ILV_W-1:0] addr_ilv,
  output logic             hit,
  output logic             deny
);
  logic in_range;
  logic ilv_ok;
  logic type_ok;
  logic placed;

  assign in_range = (addr_fld >= lo) && (addr_fld <= hi);
  assign ilv_ok   = ((addr_ilv ^ sel) & mask) == '0;
  assign type_ok  = is_write ? wr_en : rd_en;
  assign placed   = in_range && ilv_ok;
  assign hit      = placed && type_ok;
  assign deny     = placed && (rd_en || wr_en) && !type_ok;
endmodule

// File: rtl/drr_pick.sv
module drr_pick #(
  parameter int NUM_WIN = 8,
  parameter int NODE_W  = 3,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0]             hits,
  input  logic [NUM_WIN-1:0][NODE_W-1:0] nodes,
  output logic                           any,
  output logic [IDX_W-1:0]               idx,
  output logic [NODE_W-1:0]              node
);
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    node = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        node = nodes[i];
      end
    end
  end
endmodule

// File: rtl/dram_node_router.sv
module dram_node_router
  import drr_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int ADDR_W  = 40,
  parameter int FLD_W   = 16,
  parameter int NODE_W  = 3,
  parameter int CFG_W   = 32,
  parameter int ILV_LSB = 12,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel_limit,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [NODE_W-1:0] rsp_node,
  output logic [IDX_W-1:0]  rsp_region,
  output logic              rsp_denied,
  output logic              cfg_err
);
  logic [NUM_WIN-1:0]              win_rd, win_wr;
  logic [NUM_WIN-1:0][ILV_W-1:0]   win_mask, win_sel;
  logic [NUM_WIN-1:0][NODE_W-1:0]  win_node;
  logic [NUM_WIN-1:0][FLD_W-1:0]   win_lo, win_hi;
  logic [NUM_WIN-1:0]              hit_vec, deny_vec;

  logic              pick_any;
  logic [IDX_W-1:0]  pick_idx;
  logic [NODE_W-1:0] pick_node;

  logic              valid_d, hit_d, deny_d, out_en;
  logic [NODE_W-1:0] node_d;
  logic [IDX_W-1:0]  region_d;

  drr_regfile #(
    .NUM_WIN(NUM_WIN), .FLD_W(FLD_W), .NODE_W(NODE_W), .CFG_W(CFG_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel_limit(cfg_sel_limit),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .win_rd(win_rd), .win_wr(win_wr), .win_mask(win_mask),
    .win_sel(win_sel), .win_node(win_node),
    .win_lo(win_lo), .win_hi(win_hi), .err_flag(cfg_err)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
    drr_window_match #(.FLD_W(FLD_W)) u_match (
      .rd_en(win_rd[g]), .wr_en(win_wr[g]),
      .mask(win_mask[g]), .sel(win_sel[g]),
      .lo(win_lo[g]), .hi(win_hi[g]),
      .is_write(req_write),
      .addr_fld(req_addr[ADDR_W-1 -: FLD_W]),
      .addr_ilv(req_addr[ILV_LSB +: ILV_W]),
      .hit(hit_vec[g]), .deny(deny_vec[g])
    );
  end

  drr_pick #(.NUM_WIN(NUM_WIN), .NODE_W(NODE_W)) u_pick (
    .hits(hit_vec), .nodes(win_node),
    .any(pick_any), .idx(pick_idx), .node(pick_node)
  );

  always_comb begin
    valid_d  = req_valid;
    hit_d    = req_valid && pick_any;
    deny_d   = req_valid && !pick_any && (|deny_vec);
    node_d   = hit_d ? pick_node : '0;
    region_d = hit_d ? pick_idx  : '0;
    out_en   = req_valid || rsp_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_denied <= 1'b0;
      rsp_node   <= '0;
      rsp_region <= '0;
    end else if (out_en) begin
      rsp_valid  <= valid_d;
      rsp_hit    <= hit_d;
      rsp_denied <= deny_d;
      rsp_node   <= node_d;
      rsp_region <= region_d;
    end
  end
endmodule

// File: rtl/drr_checker.sv
module drr_checker
  import drr_pkg::*;
#(
  parameter int NODE_W = 3,
  parameter int IDX_W  = 3,
  parameter int CFG_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_sel_limit,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [NODE_W-1:0] rsp_node,
  input logic [IDX_W-1:0]  rsp_region,
  input logic              rsp_denied,
  input logic              cfg_err
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R7

  AST_RSP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R7

  AST_HIT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_denied)); // R10

  AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_node == '0 && rsp_region == '0)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_denied)); // R7

  AST_CFG_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R5

  AST_CFG_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel_limit && ilv_reserved(cfg_wdata[10:8])) |=> cfg_err); // R5
endmodule

bind dram_node_router drr_checker #(
  .NODE_W(NODE_W), .IDX_W(IDX_W), .CFG_W(CFG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel_limit(cfg_sel_limit),
  .cfg_wdata(cfg_wdata), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_node(rsp_node), .rsp_region(rsp_region),
  .rsp_denied(rsp_denied), .cfg_err(cfg_err)
);

// File: tb/dram_node_router_test.sv
`timescale 1ns/1ps
module dram_node_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel_limit = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [39:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_denied, cfg_err;
  logic [2:0]  rsp_node, rsp_region;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dram_node_router uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel_limit(cfg_sel_limit),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_node(rsp_node), .rsp_region(rsp_region),
    .rsp_denied(rsp_denied), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] fld;
    logic [2:0]  low;
    logic        hit;
    logic [2:0]  node;
    logic [2:0]  win;
    logic        den;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 16'h0010, 3'b000, 1'b1, 3'd2, 3'd0, 1'b0}, // R6 overlap, low wins
    '{1'b1, 16'h003F, 3'b000, 1'b1, 3'd2, 3'd0, 1'b0}, // R2 upper bound
    '{1'b0, 16'h0000, 3'b000, 1'b1, 3'd2, 3'd0, 1'b0}, // R2 lower bound
    '{1'b0, 16'h0040, 3'b000, 1'b1, 3'd5, 3'd1, 1'b0}, // R3 read allowed
    '{1'b1, 16'h0050, 3'b000, 1'b0, 3'd0, 3'd0, 1'b1}, // R3 write denied
    '{1'b0, 16'h0080, 3'b000, 1'b1, 3'd1, 3'd2, 1'b0}, // R4 two-way A12=0
    '{1'b0, 16'h00FF, 3'b001, 1'b1, 3'd3, 3'd3, 1'b0}, // R4 two-way A12=1
    '{1'b1, 16'h0100, 3'b101, 1'b1, 3'd4, 3'd4, 1'b0}, // R4 four-way
    '{1'b0, 16'h0100, 3'b111, 1'b1, 3'd4, 3'd4, 1'b0}, // R4 four-way ignores A13
    '{1'b0, 16'h0150, 3'b010, 1'b1, 3'd6, 3'd5, 1'b0}, // R4 eight-way
    '{1'b0, 16'h0150, 3'b011, 1'b0, 3'd0, 3'd0, 1'b0}, // R8 interleave miss
    '{1'b0, 16'h0300, 3'b000, 1'b0, 3'd0, 3'd0, 1'b0}, // R8 gap
    '{1'b1, 16'hFFFF, 3'b111, 1'b0, 3'd0, 3'd0, 1'b0}  // R8 top of space
  };

  function automatic logic [39:0] mk_addr(input logic [15:0] f, input logic [2:0] l);
    mk_addr = {f, 24'h0} | (40'(l) << 12);
  endfunction

  function automatic logic [31:0] base_w(input logic [15:0] lo, input logic [2:0] code,
                                         input logic we, input logic re);
    base_w = {lo, 5'b0, code, 6'b0, we, re};
  endfunction

  function automatic logic [31:0] lim_w(input logic [15:0] hi, input logic [2:0] sel,
                                        input logic [2:0] node);
    lim_w = {hi, 5'b0, sel, 5'b0, node};
  endfunction

  task automatic cfg_write(input logic lim, input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel_limit = lim; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_win(input logic [2:0] idx, input logic [15:0] lo, input logic [15:0] hi,
                         input logic [2:0] code, input logic [2:0] sel,
                         input logic [2:0] node, input logic we, input logic re);
    cfg_write(1'b1, idx, lim_w(hi, sel, node));
    cfg_write(1'b0, idx, base_w(lo, code, we, re));
  endtask

  // Present one request; the result is registered at the next rising edge.
  task automatic do_req(input logic wr, input logic [39:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check(input string req, input logic hit, input logic [2:0] node,
                       input logic [2:0] win, input logic den);
    n_run++;
    if (!(rsp_valid === 1'b1 && rsp_hit === hit && rsp_node === node &&
          rsp_region === win && rsp_denied === den)) begin
      n_fail++;
      $display("FAIL %s: got v=%b hit=%b node=%0d win=%0d den=%b exp v=1 hit=%b node=%0d win=%0d den=%b",
               req, rsp_valid, rsp_hit, rsp_node, rsp_region, rsp_denied, hit, node, win, den);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b exp %b", req, got, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check_bit("R9 rsp_valid after reset", rsp_valid, 1'b0);
    check_bit("R9 cfg_err after reset", cfg_err, 1'b0);
    rst_n = 1'b1;
    do_req(1'b0, mk_addr(16'h0010, 3'b000));
    check("R9 windows disabled", 1'b0, 3'd0, 3'd0, 1'b0);

    // R1: program windows, limits before bases
    set_win(3'd0, 16'h0000, 16'h003F, 3'b000, 3'b000, 3'd2, 1'b1, 1'b1);
    set_win(3'd1, 16'h0040, 16'h007F, 3'b000, 3'b000, 3'd5, 1'b0, 1'b1);
    set_win(3'd2, 16'h0080, 16'h00FF, 3'b001, 3'b000, 3'd1, 1'b1, 1'b1);
    set_win(3'd3, 16'h0080, 16'h00FF, 3'b001, 3'b001, 3'd3, 1'b1, 1'b1);
    set_win(3'd4, 16'h0100, 16'h01FF, 3'b011, 3'b101, 3'd4, 1'b1, 1'b1);
    set_win(3'd5, 16'h0100, 16'h01FF, 3'b111, 3'b010, 3'd6, 1'b1, 1'b1);
    set_win(3'd6, 16'h0000, 16'h0010, 3'b000, 3'b000, 3'd7, 1'b1, 1'b1);
    check_bit("R5 legal codes leave cfg_err low", cfg_err, 1'b0);

    for (int i = 0; i < NV; i++) begin
      do_req(TBL[i].wr, mk_addr(TBL[i].fld, TBL[i].low));
      check($sformatf("R1/R2/R3/R4/R6/R8 vector %0d", i),
            TBL[i].hit, TBL[i].node, TBL[i].win, TBL[i].den);
    end

    // R7: valid drops the cycle after the request goes away
    @(negedge clk);
    check_bit("R7 rsp_valid idle", rsp_valid, 1'b0);

    // R7: only the limit is written, so window 7 is still off
    cfg_write(1'b1, 3'd7, lim_w(16'h020F, 3'b000, 3'd7));
    do_req(1'b0, mk_addr(16'h0205, 3'b110));
    check("R7 limit alone does not enable", 1'b0, 3'd0, 3'd0, 1'b0);

    // R5: reserved code 010 acts as no interleave and sets the flag
    cfg_write(1'b0, 3'd7, base_w(16'h0200, 3'b010, 1'b0, 1'b1));
    do_req(1'b0, mk_addr(16'h0205, 3'b110));
    check("R5 reserved code no interleave", 1'b1, 3'd7, 3'd7, 1'b0);
    check_bit("R5 cfg_err set", cfg_err, 1'b1);

    // R5 sticky; R3 denied on read-only window
    cfg_write(1'b0, 3'd7, base_w(16'h0200, 3'b000, 1'b0, 1'b1));
    check_bit("R5 cfg_err sticky", cfg_err, 1'b1);
    do_req(1'b1, mk_addr(16'h0205, 3'b000));
    check("R3 write to read-only window", 1'b0, 3'd0, 3'd0, 1'b1);

    // R6: disable window 0, overlapping window 6 takes over
    cfg_write(1'b0, 3'd0, 32'h0);
    do_req(1'b0, mk_addr(16'h0010, 3'b000));
    check("R6 next window wins", 1'b1, 3'd7, 3'd6, 1'b0);
    do_req(1'b0, mk_addr(16'h0020, 3'b000));
    check("R8 disabled window misses", 1'b0, 3'd0, 3'd0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule